// File: doc/BRIEF.md
# Mode-Banked Register Switcher

This block keeps the mode-private copies of the upper general registers of a 32-bit processor core and exchanges them whenever the operating mode changes. It holds the live values of R8 to R14 and the saved status word, together with a shadow set of stack pointer, link register and saved status for every bank. It also keeps two shadow sets of R8 to R12: one for the fast-interrupt mode and one shared by all other modes.

The core asks for a new mode by pulsing a strobe with the requested encoding. The block saves the outgoing values in one cycle and loads the incoming values in the next, then pulses `done`. If the request names the mode already in force, nothing happens. If it names an encoding the block does not know, an error pulse is raised and no switch takes place. While the block is idle, the core writes the live registers through a simple write port and sees them all at once on a flat output bus.

Top module: `mode_bank_switch`

## Requirements
- R1: After reset the mode is supervisor (0x13), every live and shadow register is zero, and `busy`, `done` and `err` are low.
- R2: Mode encodings are user 0x10, FIQ 0x11, IRQ 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. User and system use bank 0, supervisor uses bank 1, abort bank 2, undefined bank 3, IRQ bank 4 and FIQ bank 5. A switch between user and system therefore leaves R13, R14 and the saved status unchanged.
- R3: A request for the mode already in force has no effect: `busy` and `done` stay low and every live register keeps its value.
- R4: On a switch, live R13, R14 and the saved status are stored into the outgoing mode's bank, then loaded from the incoming mode's bank. A return to a mode therefore recovers its earlier values.
- R5: Leaving FIQ stores live R8–R12 into the FIQ set and loads them from the user set.
- R6: Entering FIQ from another mode stores live R8–R12 into the user set and loads them from the FIQ set. A switch that neither enters nor leaves FIQ leaves R8–R12 unchanged.
- R7: A request naming any other encoding raises `err` for one cycle, in the cycle after the request. No switch occurs and all state is kept.
- R8: An accepted request drives `busy` high for the two cycles after the request edge (save, then load). The new mode and registers appear at the second edge, and `done` is high for exactly the one cycle that follows.
- R9: `wr_sel` 0–6 selects live R8–R14 and 7 selects the saved status; `act_flat` carries select i in bits [i*DATA_W +: DATA_W]. A write while `busy` is ignored. A write in the same cycle as an accepted request is applied first, so it reaches the outgoing bank.
- R10: A switch request made while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | 1 | Switch request strobe |
| sw_mode | input | 5 | Requested mode encoding |
| wr_en | input | 1 | Live register write enable |
| wr_sel | input | 3 | Live register select (0–6 R8–R14, 7 saved status) |
| wr_data | input | DATA_W | Write data |
| act_flat | output | 8*DATA_W | All live registers, select i at [i*DATA_W +: DATA_W] |
| cur_mode | output | 5 | Mode in force |
| busy | output | 1 | Switch in progress |
| done | output | 1 | One-cycle pulse after a completed switch |
| err | output | 1 | One-cycle pulse for an unknown mode request |

## Verification
A register write and a switch request can share a cycle. The bench drives both on the same edge, changing R14 while asking for abort mode, and then returns to the first mode. The written value must come back from the outgoing bank, not the value held before the write. The bench also sends a write and a second request during the save cycle of a switch, and checks through the final register image and mode that both were dropped.

// File: rtl/mbank_pkg.sv
package mbank_pkg;

    localparam int MODE_W    = 5;
    localparam int NUM_BANKS = 6;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int HI_REGS   = 5;               // R8..R12
    localparam int ACT_REGS  = HI_REGS + 3;     // + R13, R14, saved status
    localparam int SEL_W     = $clog2(ACT_REGS);
    localparam int IDX_SP    = HI_REGS;
    localparam int IDX_LR    = HI_REGS + 1;
    localparam int IDX_PSR   = HI_REGS + 2;

    localparam logic [MODE_W-1:0] M_USR = 5'h10;
    localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] M_SVC = 5'h13;
    localparam logic [MODE_W-1:0] M_ABT = 5'h17;
    localparam logic [MODE_W-1:0] M_UND = 5'h1B;
    localparam logic [MODE_W-1:0] M_SYS = 5'h1F;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SAVE = 2'd1,
        PH_LOAD = 2'd2
    } phase_e;

    typedef struct packed {
        logic              save;
        logic              load;
        logic [BANK_W-1:0] from_bank;
        logic [BANK_W-1:0] to_bank;
        logic              enter_fiq;
        logic              leave_fiq;
    } xfer_t;

    function automatic logic mode_known(input logic [MODE_W-1:0] m);
        case (m)
            M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
            default:                                         return 1'b0;
        endcase
    endfunction

    function automatic logic [BANK_W-1:0] bank_of(input logic [MODE_W-1:0] m);
        case (m)
            M_SVC:   return BANK_W'(1);
            M_ABT:   return BANK_W'(2);
            M_UND:   return BANK_W'(3);
            M_IRQ:   return BANK_W'(4);
            M_FIQ:   return BANK_W'(5);
            default: return BANK_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/mbank_fsm.sv
module mbank_fsm
    import mbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_req,
    input  logic [MODE_W-1:0] sw_mode,
    output logic [MODE_W-1:0] cur_mode,
    output logic              busy,
    output logic              done,
    output logic              err,
    output xfer_t             xfer
);

    phase_e            phase_q;
    logic [MODE_W-1:0] cur_q;
    logic [MODE_W-1:0] tgt_q;
    logic              done_q;
    logic              err_q;
    logic              idle;
    logic              accept;
    logic              bad;

    assign idle   = (phase_q == PH_IDLE);
    assign bad    = idle && sw_req && !mode_known(sw_mode);
    assign accept = idle && sw_req && mode_known(sw_mode) && (sw_mode != cur_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cur_q   <= M_SVC;
            tgt_q   <= M_SVC;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= (phase_q == PH_LOAD);
            err_q  <= bad;
            case (phase_q)
                PH_IDLE: if (accept) begin
                    tgt_q   <= sw_mode;
                    phase_q <= PH_SAVE;
                end
                PH_SAVE: phase_q <= PH_LOAD;
                PH_LOAD: begin
                    cur_q   <= tgt_q;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        xfer.save      = (phase_q == PH_SAVE);
        xfer.load      = (phase_q == PH_LOAD);
        xfer.from_bank = bank_of(cur_q);
        xfer.to_bank   = bank_of(tgt_q);
        xfer.enter_fiq = (tgt_q == M_FIQ) && (cur_q != M_FIQ);
        xfer.leave_fiq = (cur_q == M_FIQ) && (tgt_q != M_FIQ);
    end

    assign cur_mode = cur_q;
    assign busy     = !idle;
    assign done     = done_q;
    assign err      = err_q;

endmodule

// File: rtl/mbank_shadow.sv
module mbank_shadow
    import mbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  xfer_t                              xfer,
    input  logic [ACT_REGS-1:0][DATA_W-1:0]    live,
    output logic [ACT_REGS-1:0][DATA_W-1:0]    incoming
);

    logic [NUM_BANKS-1:0][DATA_W-1:0] sh_sp;
    logic [NUM_BANKS-1:0][DATA_W-1:0] sh_lr;
    logic [NUM_BANKS-1:0][DATA_W-1:0] sh_psr;
    logic [HI_REGS-1:0][DATA_W-1:0]   usr_hi;
    logic [HI_REGS-1:0][DATA_W-1:0]   fiq_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_sp  <= '0;
            sh_lr  <= '0;
            sh_psr <= '0;
            usr_hi <= '0;
            fiq_hi <= '0;
        end else if (xfer.save) begin
            sh_sp[xfer.from_bank]  <= live[IDX_SP];
            sh_lr[xfer.from_bank]  <= live[IDX_LR];
            sh_psr[xfer.from_bank] <= live[IDX_PSR];
            if (xfer.leave_fiq)
                fiq_hi <= live[HI_REGS-1:0];
            else if (xfer.enter_fiq)
                usr_hi <= live[HI_REGS-1:0];
        end
    end

    generate
        for (genvar g = 0; g < HI_REGS; g++) begin : g_hi
            assign incoming[g] = xfer.enter_fiq ? fiq_hi[g] : usr_hi[g];
        end
    endgenerate

    assign incoming[IDX_SP]  = sh_sp[xfer.to_bank];
    assign incoming[IDX_LR]  = sh_lr[xfer.to_bank];
    assign incoming[IDX_PSR] = sh_psr[xfer.to_bank];

endmodule

// File: rtl/mode_bank_switch.sv
module mode_bank_switch
    import mbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sw_req,
    input  logic [4:0]                 sw_mode,
    input  logic                       wr_en,
    input  logic [2:0]                 wr_sel,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [8*DATA_W-1:0]        act_flat,
    output logic [4:0]                 cur_mode,
    output logic                       busy,
    output logic                       done,
    output logic                       err
);

    xfer_t                           xfer;
    logic [ACT_REGS-1:0][DATA_W-1:0] act_q;
    logic [ACT_REGS-1:0][DATA_W-1:0] incoming;
    logic                            hi_swap;

    mbank_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sw_req   (sw_req),
        .sw_mode  (sw_mode),
        .cur_mode (cur_mode),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .xfer     (xfer)
    );

    mbank_shadow #(.DATA_W(DATA_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .xfer     (xfer),
        .live     (act_q),
        .incoming (incoming)
    );

    assign hi_swap = xfer.enter_fiq || xfer.leave_fiq;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else if (xfer.load) begin
            for (int i = 0; i < ACT_REGS; i++) begin
                if (i >= HI_REGS || hi_swap)
                    act_q[i] <= incoming[i];
            end
        end else if (wr_en && !busy) begin
            act_q[wr_sel] <= wr_data;
        end
    end

    assign act_flat = act_q;

endmodule

// File: rtl/mode_bank_chk.sv
module mode_bank_chk
    import mbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                sw_req,
    input logic [4:0]          sw_mode,
    input logic [8*DATA_W-1:0] act_flat,
    input logic [4:0]          cur_mode,
    input logic                busy,
    input logic                done,
    input logic                err
);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    mode_moves_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_mode) |-> done);

    // R2
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mode_known(cur_mode));

    // R3
    noop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_req && !busy && sw_mode == cur_mode) |=> !busy);

    // R7
    bad_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_req && !busy && !mode_known(sw_mode)) |=> (err && !busy));

    // R8
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_req && !busy && mode_known(sw_mode) && sw_mode != cur_mode) |=> busy);

    // R9
    save_cycle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> $stable(act_flat));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !$rose(busy)) |=> !busy);

endmodule

bind mode_bank_switch mode_bank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sw_req   (sw_req),
    .sw_mode  (sw_mode),
    .act_flat (act_flat),
    .cur_mode (cur_mode),
    .busy     (busy),
    .done     (done),
    .err      (err)
);

// File: tb/tb_mode_bank_switch.sv
module tb_mode_bank_switch;

    localparam int DW = 32;
    localparam int FW = 8 * DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sw_req = 1'b0;
    logic [4:0]    sw_mode = 5'h0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = 3'd0;
    logic [DW-1:0] wr_data = '0;
    logic [FW-1:0] act_flat;
    logic [4:0]    cur_mode;
    logic          busy, done, err;

    always #2.5 clk = ~clk;

    mode_bank_switch #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .sw_req(sw_req), .sw_mode(sw_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .act_flat(act_flat), .cur_mode(cur_mode),
        .busy(busy), .done(done), .err(err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model
    logic [4:0]    m_mode;
    logic [DW-1:0] m_act [8];
    logic [DW-1:0] m_sp [6], m_lr [6], m_psr [6];
    logic [DW-1:0] m_usr [5], m_fiq [5];

    typedef struct packed { logic [4:0] mode; logic [FW-1:0] regs; } exp_t;
    exp_t exp_q [$];

    function automatic int bank(input logic [4:0] m);
        case (m)
            5'h13: return 1;
            5'h17: return 2;
            5'h1B: return 3;
            5'h12: return 4;
            5'h11: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic [FW-1:0] model_flat();
        logic [FW-1:0] f;
        for (int i = 0; i < 8; i++) f[i*DW +: DW] = m_act[i];
        return f;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [FW-1:0] a, input logic [FW-1:0] e);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    task automatic model_switch(input logic [4:0] m);
        int bo, bn;
        bo = bank(m_mode);
        bn = bank(m);
        m_sp[bo] = m_act[5]; m_lr[bo] = m_act[6]; m_psr[bo] = m_act[7];
        if (m_mode == 5'h11) begin
            for (int i = 0; i < 5; i++) begin m_fiq[i] = m_act[i]; m_act[i] = m_usr[i]; end
        end else if (m == 5'h11) begin
            for (int i = 0; i < 5; i++) begin m_usr[i] = m_act[i]; m_act[i] = m_fiq[i]; end
        end
        m_act[5] = m_sp[bn]; m_act[6] = m_lr[bn]; m_act[7] = m_psr[bn];
        m_mode = m;
        exp_q.push_back('{mode: m, regs: model_flat()});
    endtask

    task automatic wr(input logic [2:0] s, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = d;
        m_act[s] = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    // R8 timing around an accepted switch; optional same-cycle write (R9)
    task automatic do_switch(input logic [4:0] m, input bit w = 0,
                             input logic [2:0] s = 0, input logic [DW-1:0] d = 0);
        @(negedge clk);
        sw_req = 1; sw_mode = m;
        if (w) begin wr_en = 1; wr_sel = s; wr_data = d; m_act[s] = d; end
        model_switch(m);
        @(negedge clk);
        sw_req = 0; wr_en = 0;
        chk(busy && !done, "R8 save busy", {busy, done}, 2'b10);
        @(negedge clk);
        chk(busy && !done, "R8 load busy", {busy, done}, 2'b10);
        @(negedge clk);
        chk(!busy && done, "R8 done", {busy, done}, 2'b01);
        @(negedge clk);
        chk(!done, "R8 done single", done, 0);
    endtask

    // monitor: compares switch results against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R4 unexpected done", cur_mode, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cur_mode == e.mode, "R2 mode after switch", cur_mode, e.mode);
                chk(act_flat == e.regs, "R4 R5 R6 registers after switch", act_flat, e.regs);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] snap;
        m_mode = 5'h13;
        for (int i = 0; i < 8; i++) m_act[i] = '0;
        for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; m_psr[i] = '0; end
        for (int i = 0; i < 5; i++) begin m_usr[i] = '0; m_fiq[i] = '0; end

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(cur_mode == 5'h13, "R1 reset mode", cur_mode, 5'h13);
        chk(act_flat == '0, "R1 reset regs", act_flat, '0);
        chk(!busy && !done && !err, "R1 reset flags", {busy, done, err}, 0);

        // fill supervisor registers (R9 select encoding)
        for (int i = 0; i < 8; i++) wr(3'(i), 32'h5000_0000 + i);
        chk(act_flat == model_flat(), "R9 write select", act_flat, model_flat());

        // R4: go to IRQ and back
        do_switch(5'h12);
        chk(act_flat[5*DW +: DW] == 0, "R4 IRQ bank fresh", act_flat[5*DW +: DW], 0);
        wr(3'd5, 32'h1111_aaaa); wr(3'd7, 32'h1111_cccc);
        do_switch(5'h13);
        chk(act_flat[5*DW +: DW] == 32'h5000_0005, "R4 round trip", act_flat[5*DW +: DW], 32'h5000_0005);

        // R6: enter FIQ
        do_switch(5'h11);
        chk(act_flat[0 +: DW] == 0, "R6 FIQ hi set loaded", act_flat[0 +: DW], 0);
        for (int i = 0; i < 7; i++) wr(3'(i), 32'hF100_0000 + i);
        // R5: leave FIQ to user
        do_switch(5'h10);
        chk(act_flat[0 +: DW] == 32'h5000_0000, "R5 user hi restored", act_flat[0 +: DW], 32'h5000_0000);
        wr(3'd5, 32'hA5A5_0013); wr(3'd6, 32'hA5A5_0014);
        // R2: user and system share a bank
        snap = act_flat;
        do_switch(5'h1F);
        chk(act_flat == snap, "R2 shared bank", act_flat, snap);
        // R5 R6: back into FIQ recovers FIQ hi set
        do_switch(5'h11);
        chk(act_flat[4*DW +: DW] == 32'hF100_0004, "R6 FIQ hi recovered", act_flat[4*DW +: DW], 32'hF100_0004);
        do_switch(5'h1B);
        chk(act_flat[0 +: DW] == 32'h5000_0000, "R5 leave to undefined", act_flat[0 +: DW], 32'h5000_0000);

        // R3: no-op request
        snap = act_flat;
        @(negedge clk); sw_req = 1; sw_mode = 5'h1B;
        @(negedge clk); sw_req = 0;
        for (int k = 0; k < 3; k++) begin
            chk(!busy && !done, "R3 no-op flags", {busy, done}, 0);
            @(negedge clk);
        end
        chk(act_flat == snap && cur_mode == 5'h1B, "R3 no-op regs", act_flat, snap);

        // R7: unknown encoding
        @(negedge clk); sw_req = 1; sw_mode = 5'h05;
        @(negedge clk); sw_req = 0;
        chk(err && !busy, "R7 err pulse", {err, busy}, 2'b10);
        @(negedge clk);
        chk(!err && cur_mode == 5'h1B && act_flat == snap, "R7 no switch", {err, cur_mode}, {1'b0, 5'h1B});

        // R9: write in the same cycle as the request reaches the outgoing bank
        do_switch(5'h17, 1, 3'd6, 32'hBEEF_0006);
        do_switch(5'h1B);
        chk(act_flat[6*DW +: DW] == 32'hBEEF_0006, "R9 same-cycle write saved", act_flat[6*DW +: DW], 32'hBEEF_0006);

        // R9 R10: write and request during the save cycle are dropped
        @(negedge clk); sw_req = 1; sw_mode = 5'h13;
        model_switch(5'h13);
        @(negedge clk); sw_req = 1; sw_mode = 5'h12; wr_en = 1; wr_sel = 3'd0; wr_data = 32'hDEAD_DEAD;
        @(negedge clk); sw_req = 0; wr_en = 0;
        @(negedge clk);
        chk(done, "R10 first switch completes", done, 1);
        repeat (3) begin
            @(negedge clk);
            chk(!busy && !done && cur_mode == 5'h13, "R10 second request dropped", {busy, done, cur_mode}, {2'b00, 5'h13});
        end
        chk(act_flat[0 +: DW] == m_act[0], "R9 busy write dropped", act_flat[0 +: DW], m_act[0]);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule